// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM with burst addressing and a pipelined read path. A parameter sets the depth. The data word is split into byte lanes, and each lane carries eight data bits plus one parity bit that is stored as written. Address, chip enables, both address strobes, the advance input and all write controls are captured on the rising clock edge. Read data passes through an output register, so it emerges one edge after the address register loads. A 2-bit burst offset then walks the other three words of the aligned group of four, in either interleaved or linear order.

Two strobes can start an access. The processor strobe counts only when the primary enable is asserted, and it always starts a read. The controller strobe starts a read or a write, as the write controls select. Either strobe seen with the chip not fully enabled deselects the device. Writes are controlled at three levels: global write, byte-write enable and one enable per lane. The output enable gates the data output without a clock. A high-impedance bus is modelled as a valid flag with the data forced to zero.

Top module: `burst_sram`

## Requirements
- R1: The chip is fully enabled when ceN=0, ceHi=1 and ceLoN=0. When procStrobeN=0 and ceN=0 with the chip fully enabled, a new access starts at addrIn with burst offset zero. That access is a read even if write controls are asserted, and no lane of the array is changed.
- R2: With ceN=1, a low procStrobeN is ignored and a running burst carries on unchanged. With procStrobeN=0, ceN=0 and ceHi=0 or ceLoN=1, the device is deselected.
- R3: When procStrobeN is not taken and ctrlStrobeN=0, a chip that is fully enabled starts an access at addrIn, and that access reads or writes as the write controls select. A chip that is not fully enabled is deselected instead.
- R4: Read data for an address registered at edge N appears on rdData, with rdValid=1, after edge N+1 and not before. Each further burst word appears one edge after the one before it.
- R5: When no strobe is taken during an active access and advanceN=0, the 2-bit offset k increments. With linearOrder=0 the low two address bits become start[1:0] XOR k. With linearOrder=1 they become (start[1:0]+k) mod 4. The upper address bits never change.
- R6: When no strobe is taken and advanceN=1, the current address is held, so a read returns the same word again.
- R7: globalWrN=0 writes all lanes, including their parity bits, regardless of byteWrEnN and laneWrN.
- R8: With globalWrN=1 and byteWrEnN=0, only lanes with laneWrN[l]=0 are written. Lane l is wrData[9l+8:9l] and its bit 8 is the parity bit. If no lane is selected, or byteWrEnN=1, the cycle is a read.
- R9: rdValid goes low after the edge that follows a deselect edge. An edge that performs a write also yields rdValid=0 after the following edge.
- R10: outEnN=1 forces rdValid=0 and rdData=0 at once, without a clock. Lowering outEnN restores the pipelined word that is being held.
- R11: A read that starts on the edge after a write to the same address returns the newly written word.
- R12: After reset no access is active: rdValid stays low while no strobe is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of pipeline state |
| addrIn | input | ADDR_W | Word address |
| ceN | input | 1 | Primary chip enable, active low (qualifies processor strobe) |
| ceHi | input | 1 | Depth-expansion enable, active high |
| ceLoN | input | 1 | Depth-expansion enable, active low |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneWrN | input | LANES | Per-lane write enables, active low |
| wrData | input | LANES*(LANE_BITS+1) | Write data, parity bit at the top of each lane |
| linearOrder | input | 1 | Burst order: 1 linear, 0 interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| rdData | output | LANES*(LANE_BITS+1) | Read data, zero when not driven |
| rdValid | output | 1 | Output drivers active |

## Verification
The bench first confirms that no word appears one edge after the strobe. A design that left out the output register would put data out too early. It then walks interleaved and linear bursts from unaligned start addresses. An offset added where it should be XORed, or a carry into the upper bits, would return the wrong word. A processor-strobe start is driven with global write asserted. A design that honoured that write would corrupt the stored word. The processor strobe is also driven with the primary enable high, and a design that did not ignore it would jump away from the running burst. A deselect is followed by one still-valid output and then silence, so a model that cut the outputs at once, or never cut them, fails. Byte-masked writes are checked lane by lane. The bench also checks that a byte-write enable with no lane selected leaves memory unchanged and reads back.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCycle;  // write the selected lanes at this edge
    logic rdPend;   // a read was registered at the last edge
  } ctl_s;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceN,
  input  logic              ceHi,
  input  logic              ceLoN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              linearOrder,
  output ctl_s              ctl,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LANES-1:0]  laneSel
);

  logic              enabled, procTaken, ctrlTaken;
  logic              startAny, deselNow, contNow;
  logic              active, rdPendQ;
  logic [ADDR_W-1:0] baseQ, addrQ, nxtBase, nxtAddr;
  logic [1:0]        cntQ, nxtCnt, offs;
  logic [LANES-1:0]  maskRaw;
  op_e               opNow;

  // cycle decode
  always_comb begin
    enabled   = !ceN && ceHi && !ceLoN;
    procTaken = !procStrobeN && !ceN;
    ctrlTaken = !procTaken && !ctrlStrobeN;
    startAny  = (procTaken || ctrlTaken) && enabled;
    deselNow  = (procTaken || ctrlTaken) && !enabled;
    contNow   = !procTaken && !ctrlTaken && active;

    if (!globalWrN)      maskRaw = '1;
    else if (!byteWrEnN) maskRaw = ~laneWrN;
    else                 maskRaw = '0;

    if (procTaken && enabled)      opNow = OP_READ;
    else if (startAny || contNow)  opNow = (|maskRaw) ? OP_WRITE : OP_READ;
    else                           opNow = OP_NONE;
  end

  // burst address generation
  always_comb begin
    nxtBase = startAny ? addrIn : baseQ;
    if (startAny)                  nxtCnt = 2'd0;
    else if (contNow && !advanceN) nxtCnt = cntQ + 2'd1;
    else                           nxtCnt = cntQ;
    offs    = linearOrder ? (nxtBase[1:0] + nxtCnt) : (nxtBase[1:0] ^ nxtCnt);
    nxtAddr = {nxtBase[ADDR_W-1:2], offs};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      baseQ   <= '0;
      cntQ    <= '0;
      addrQ   <= '0;
      rdPendQ <= 1'b0;
    end else begin
      if (startAny)      active <= 1'b1;
      else if (deselNow) active <= 1'b0;
      if (startAny || contNow) begin
        baseQ <= nxtBase;
        cntQ  <= nxtCnt;
        addrQ <= nxtAddr;
      end
      rdPendQ <= (opNow == OP_READ);
    end
  end

  assign wrAddr      = nxtAddr;
  assign rdAddr      = addrQ;
  assign laneSel     = maskRaw;
  assign ctl.wrCycle = (opNow == OP_WRITE);
  assign ctl.rdPend  = rdPendQ;

  AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (procTaken && enabled) |-> !ctl.wrCycle);  // R1

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (contNow && advanceN) |=> $stable(rdAddr));  // R6

  AST_BURST_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (contNow && !advanceN) |=> (rdAddr[ADDR_W-1:2] == $past(rdAddr[ADDR_W-1:2])) && (rdAddr != $past(rdAddr)));  // R5

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!globalWrN && !procTaken && (startAny || contNow)) |-> (ctl.wrCycle && (&laneSel)));  // R7

  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    deselNow |=> (!active && !ctl.rdPend));  // R9

endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_s                        ctl,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [LANES-1:0]            laneSel,
  input  logic [LANES*(LANE_BITS+1)-1:0] wrData,
  input  logic                        outEnN,
  output logic [LANES*(LANE_BITS+1)-1:0] rdData,
  output logic                        rdValid
);

  localparam int LANE_W = LANE_BITS + 1;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] outWord;
  logic [LANES-1:0]  laneWe;
  logic              outActive;

  assign laneWe = laneSel & {LANES{ctl.wrCycle}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (laneWe[l]) mem[wrAddr] <= wrData[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneQ <= '0;
      else       laneQ <= mem[rdAddr];
    end

    assign outWord[l*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outActive <= 1'b0;
    else       outActive <= ctl.rdPend;
  end

  assign rdValid = outActive && !outEnN;
  assign rdData  = rdValid ? outWord : '0;

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!rdValid && (rdData == '0)));  // R10

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addrIn,
  input  logic                           ceN,
  input  logic                           ceHi,
  input  logic                           ceLoN,
  input  logic                           procStrobeN,
  input  logic                           ctrlStrobeN,
  input  logic                           advanceN,
  input  logic                           globalWrN,
  input  logic                           byteWrEnN,
  input  logic [LANES-1:0]               laneWrN,
  input  logic [LANES*(LANE_BITS+1)-1:0] wrData,
  input  logic                           linearOrder,
  input  logic                           outEnN,
  output logic [LANES*(LANE_BITS+1)-1:0] rdData,
  output logic                           rdValid
);

  ctl_s              ctl;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [LANES-1:0]  laneSel;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceN(ceN), .ceHi(ceHi), .ceLoN(ceLoN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .linearOrder(linearOrder), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .laneSel(laneSel)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .laneSel(laneSel), .wrData(wrData), .outEnN(outEnN), .rdData(rdData),
    .rdValid(rdValid)
  );

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  addrIn;
  logic        ceN, ceHi, ceLoN, procStrobeN, ctrlStrobeN, advanceN;
  logic        globalWrN, byteWrEnN, linearOrder, outEnN;
  logic [3:0]  laneWrN;
  logic [35:0] wrData, rdData;
  logic        rdValid;

  logic [35:0] model [64];
  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_sram u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceN(ceN), .ceHi(ceHi), .ceLoN(ceLoN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .wrData(wrData), .linearOrder(linearOrder), .outEnN(outEnN),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [35:0] pat(input int k);
    logic [7:0] kb;
    kb = 8'(k);
    return 36'h813579BDF ^ ({28'd0, kb} * 36'h111111111);
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = '1;
    ceN = 1'b0; ceHi = 1'b1; ceLoN = 1'b0; outEnN = 1'b0;
  endtask

  task automatic desel;
    idle; ctrlStrobeN = 1'b0; ceHi = 1'b0;
    step;
    idle;
    step;
  endtask

  task automatic wrGlobal(input int a, input logic [35:0] d);
    idle; ctrlStrobeN = 1'b0; addrIn = 6'(a); globalWrN = 1'b0; wrData = d;
    step;
    model[a] = d;
    desel;
  endtask

  task automatic rdOne(input int a, input string tag);
    idle; ctrlStrobeN = 1'b0; addrIn = 6'(a);
    step;
    idle;
    step;
    chk({tag, " valid"}, {35'd0, rdValid}, 36'd1);
    chk(tag, rdData, model[a]);
    desel;
  endtask

  task automatic testReset;
    chk("R12 valid low after reset", {35'd0, rdValid}, 36'd0);
    step; step;
    chk("R12 no access without strobe", {35'd0, rdValid}, 36'd0);
  endtask

  task automatic testFill;
    for (int k = 0; k < 16; k++) wrGlobal(k, pat(k));
    rdOne(7, "R7 global write word");
  endtask

  task automatic testLatency;
    desel;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd3;
    step;
    idle;
    chk("R4 nothing after first edge", {35'd0, rdValid}, 36'd0);
    step;
    chk("R4 data after second edge", rdData, model[3]);
    desel;
  endtask

  task automatic testInterleave;
    int seq [4] = '{5, 4, 7, 6};
    desel;
    idle; linearOrder = 1'b0; procStrobeN = 1'b0; addrIn = 6'd5;
    globalWrN = 1'b0; wrData = 36'hFFFFFFFFF;
    step;
    idle; advanceN = 1'b0;
    step;
    chk("R1 processor start ignores write", rdData, model[5]);
    for (int k = 1; k < 4; k++) begin
      step;
      chk("R5 interleaved burst word", rdData, model[seq[k]]);
    end
    desel;
  endtask

  task automatic testLinear;
    int seq [4] = '{6, 7, 4, 5};
    desel;
    idle; linearOrder = 1'b1; ctrlStrobeN = 1'b0; addrIn = 6'd6;
    step;
    idle; advanceN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step;
      chk("R5 linear burst word", rdData, model[seq[k]]);
    end
    linearOrder = 1'b0;
    desel;
  endtask

  task automatic testSuspend;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd2;
    step;
    idle; advanceN = 1'b0;
    step;
    chk("R4 first burst word", rdData, model[2]);
    advanceN = 1'b1;
    step;
    chk("R4 second burst word", rdData, model[3]);
    step;
    chk("R6 suspended word repeats", rdData, model[3]);
    step;
    chk("R6 suspended word repeats again", rdData, model[3]);
    desel;
  endtask

  task automatic testByteMask;
    logic [35:0] d;
    d = 36'hABCDEF012;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd9; byteWrEnN = 1'b0; laneWrN = 4'b1010; wrData = d;
    step;
    model[9][8:0]   = d[8:0];
    model[9][26:18] = d[26:18];
    desel;
    rdOne(9, "R8 lanes 0 and 2 written");
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd9; byteWrEnN = 1'b0; laneWrN = 4'b1111; wrData = '0;
    step;
    idle;
    step;
    chk("R8 no lane selected reads", rdData, model[9]);
    desel;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd9; laneWrN = 4'b0000; wrData = '0;
    step;
    idle;
    step;
    chk("R8 byte enable high reads", rdData, model[9]);
    desel;
  endtask

  task automatic testDeselect;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd3;
    step;
    idle; ctrlStrobeN = 1'b0; ceHi = 1'b0;
    step;
    chk("R3 pending word still out", rdData, model[3]);
    idle;
    step;
    chk("R9 off after deselect", {35'd0, rdValid}, 36'd0);
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd11; globalWrN = 1'b0; wrData = 36'h123456789;
    step;
    model[11] = 36'h123456789;
    idle;
    step;
    chk("R9 no output after write edge", {35'd0, rdValid}, 36'd0);
    step;
    chk("R11 continuation reads new word", rdData, model[11]);
    desel;
  endtask

  task automatic testProcIgnore;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd10;
    step;
    idle; procStrobeN = 1'b0; ceN = 1'b1; addrIn = 6'd1;
    step;
    chk("R2 word before ignored strobe", rdData, model[10]);
    step;
    chk("R2 ignored strobe keeps burst", rdData, model[10]);
    idle; procStrobeN = 1'b0; ceHi = 1'b0;
    step;
    idle;
    step;
    chk("R2 processor deselect", {35'd0, rdValid}, 36'd0);
  endtask

  task automatic testOutEn;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd4;
    step;
    idle;
    step;
    outEnN = 1'b1;
    #1;
    chk("R10 valid gated", {35'd0, rdValid}, 36'd0);
    chk("R10 data gated", rdData, 36'd0);
    outEnN = 1'b0;
    #1;
    chk("R10 data restored", rdData, model[4]);
    desel;
  endtask

  task automatic testRaw;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd20; globalWrN = 1'b0; wrData = 36'h5A5A5A5A5;
    step;
    model[20] = 36'h5A5A5A5A5;
    idle; ctrlStrobeN = 1'b0; addrIn = 6'd20;
    step;
    idle;
    step;
    chk("R11 read after write", rdData, model[20]);
    desel;
  endtask

  initial begin
    rstN = 1'b0; addrIn = '0; wrData = '0; linearOrder = 1'b0;
    idle;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testFill;
    testLatency;
    testInterleave;
    testLinear;
    testSuspend;
    testByteMask;
    testDeselect;
    testProcIgnore;
    testOutEn;
    testRaw;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule